// File: doc/BRIEF.md
# Combining 2x2 Network Switch

This block is one switching element of a baseline multistage network that sits between many processors and many memory banks. It has two processor-side ports (`in0`, `in1`) and two memory-side ports (`out0`, `out1`). Each port carries traffic both ways: requests travel from the processor side toward memory, and replies travel back. Every port and direction has its own valid/ready handshake and its own bounded input channel, so requests and replies advance independently.

A message carries a 2-bit function code, a path field of `STAGES` two-bit symbols, a word offset and a data byte. At the top of the path sit the destination symbols that later stages still need. At the bottom sit the return-path symbols written by earlier stages. When a request leaves, the switch consumes the top symbol and appends a return symbol at the bottom. When a reply leaves, the switch consumes the bottom symbol and puts its own output-port number back at the top. The path width never changes from stage to stage.

Two reads of the same word that meet at the switch in the same cycle leave as a single request whose return symbol is a duplicate marker. When the reply carrying that marker comes back, it is delivered to both processor-side ports in one cycle. Requests that collide on one output, and replies whose targets overlap, are settled by a pseudo-random arbiter. The loser waits in its channel and tries again.

Top module: `combining_switch`

## Requirements
- R1: After reset, every output valid is low and every input ready is high, because all channels are empty.
- R2: A request leaves on `out0` when bit `PATH_W-2` of its path (the low bit of the top symbol) is 0, and on `out1` when that bit is 1. The outgoing path is the incoming path shifted up by one symbol, with the input-port symbol (`00` for `in0`, `01` for `in1`) placed in bits [1:0]. The function, word and data fields pass through unchanged.
- R3: A reply is routed by path bits [1:0]: `00` goes to `in0`, `01` goes to `in1`, and `10` or `11` (the duplicate marker) goes to both. The outgoing path is the incoming path shifted down by one symbol, with the output-port symbol (`00` for `out0`, `01` for `out1`) placed in the top two bits.
- R4: Two request heads that want different outputs are both forwarded in the same cycle.
- R5: Two request heads are combined when all of these hold: both have function `00` (read), their top `STAGES-LEVEL` path symbols are equal, and their word fields are equal. The combined request goes out once, carries the `in0` message with return symbol `10`, and both heads are consumed in the same handshake.
- R6: Two request heads that want the same output but cannot be combined produce exactly one forwarded message. The other stays at the head of its channel and competes again in the next cycle.
- R7: A reply carrying the duplicate marker is presented on `in0` and `in1` together, and only in a cycle where both readies are high. It is never delivered to one port alone.
- R8: Each input channel holds `DEPTH` (3) messages. Its ready is low exactly when it is full. A blocked head stays unchanged, and no message is lost or reordered within a channel.
- R9: Two reply heads whose target sets overlap produce exactly one winner, and the other is held. Two reply heads with disjoint targets may both be delivered in the same cycle. A reply is presented only in a cycle where all of its target ports are ready.
- R10: Requests and replies make progress in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_req_valid | input | 1 | Request offered on processor port 0 |
| in0_req_ready | output | 1 | Processor port 0 request channel not full |
| in0_req_msg | input | MSG_W | Request message on processor port 0 |
| in1_req_valid | input | 1 | Request offered on processor port 1 |
| in1_req_ready | output | 1 | Processor port 1 request channel not full |
| in1_req_msg | input | MSG_W | Request message on processor port 1 |
| out0_req_valid | output | 1 | Request presented toward memory port 0 |
| out0_req_ready | input | 1 | Downstream channel on memory port 0 can accept |
| out0_req_msg | output | MSG_W | Rewritten request on memory port 0 |
| out1_req_valid | output | 1 | Request presented toward memory port 1 |
| out1_req_ready | input | 1 | Downstream channel on memory port 1 can accept |
| out1_req_msg | output | MSG_W | Rewritten request on memory port 1 |
| out0_rsp_valid | input | 1 | Reply offered on memory port 0 |
| out0_rsp_ready | output | 1 | Memory port 0 reply channel not full |
| out0_rsp_msg | input | MSG_W | Reply message on memory port 0 |
| out1_rsp_valid | input | 1 | Reply offered on memory port 1 |
| out1_rsp_ready | output | 1 | Memory port 1 reply channel not full |
| out1_rsp_msg | input | MSG_W | Reply message on memory port 1 |
| in0_rsp_valid | output | 1 | Reply presented on processor port 0 |
| in0_rsp_ready | input | 1 | Upstream channel on processor port 0 can accept |
| in0_rsp_msg | output | MSG_W | Rewritten reply on processor port 0 |
| in1_rsp_valid | output | 1 | Reply presented on processor port 1 |
| in1_rsp_ready | input | 1 | Upstream channel on processor port 1 can accept |
| in1_rsp_msg | output | MSG_W | Rewritten reply on processor port 1 |

## Verification
The hardest case to reach is a duplicate-marked reply that waits at its channel head while only one processor-side port is ready and a second reply is also competing for that port. This is where a one-sided delivery or a lost reply would show up. The stimulus draws the reply return symbol evenly from the three legal codes and drives the two processor-side readies independently of each other. It also inserts periodic stretches with every ready held low, so channels fill and then drain under contention. Request words and destination bits come from very small sets, so combinable and conflicting pairs occur often. The reference model accepts either arbitration outcome and then follows whichever one the design actually took.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam int STAGES = 3;
    localparam int WORD_W = 4;
    localparam int DATA_W = 8;
    localparam int SYM_W  = 2;
    localparam int PATH_W = STAGES * SYM_W;

    localparam logic [1:0] FN_READ  = 2'b00;
    localparam logic [1:0] FN_WRITE = 2'b01;

    localparam logic [SYM_W-1:0] SYM_P0   = 2'b00;
    localparam logic [SYM_W-1:0] SYM_P1   = 2'b01;
    localparam logic [SYM_W-1:0] SYM_BOTH = 2'b10;

    typedef struct packed {
        logic [1:0]        fn;
        logic [PATH_W-1:0] path;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] data;
    } msg_t;

    localparam int MSG_W = $bits(msg_t);
endpackage

// File: rtl/csw_fifo.sv
module csw_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    output logic         pop_valid,
    input  logic         pop_ready,
    output logic [W-1:0] pop_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push, pop;

    assign push_ready = (count != CNT_W'(DEPTH));
    assign pop_valid  = (count != '0);
    assign pop_data   = mem[rd_ptr];
    assign push       = push_valid && push_ready;
    assign pop        = pop_valid && pop_ready;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // R8: a head that was not taken must stay put
    p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));
endmodule

// File: rtl/csw_req_router.sv
module csw_req_router
    import csw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [1:0] hv,
    input  msg_t       h0,
    input  msg_t       h1,
    input  logic       pick,
    input  logic [1:0] ordy,
    output logic [1:0] ov,
    output msg_t       o0,
    output msg_t       o1,
    output logic [1:0] pop
);
    localparam int KEY_W = (STAGES - LEVEL) * SYM_W;

    logic want0, want1, same, comb, g0, g1;
    msg_t fw0, fw1;

    always_comb begin
        want0    = h0.path[PATH_W-2];
        want1    = h1.path[PATH_W-2];
        fw0      = h0;
        fw1      = h1;
        fw0.path = {h0.path[PATH_W-SYM_W-1:0], SYM_P0};
        fw1.path = {h1.path[PATH_W-SYM_W-1:0], SYM_P1};
        same     = (hv == 2'b11) && (want0 == want1);
        comb     = same && (h0.fn == FN_READ) && (h1.fn == FN_READ)
                   && (h0.path[PATH_W-1 -: KEY_W] == h1.path[PATH_W-1 -: KEY_W])
                   && (h0.word == h1.word);
        if (comb) fw0.path[SYM_W-1:0] = SYM_BOTH;
        g0    = hv[0] && !(same && !comb && pick);
        g1    = hv[1] && !comb && !(same && !pick);
        ov[0] = (g0 && !want0) || (g1 && !want1);
        ov[1] = (g0 && want0)  || (g1 && want1);
        o0    = (g0 && !want0) ? fw0 : fw1;
        o1    = (g0 && want0)  ? fw0 : fw1;
        pop[0] = g0 && ordy[want0];
        pop[1] = comb ? pop[0] : (g1 && ordy[want1]);
    end
endmodule

// File: rtl/csw_rsp_router.sv
module csw_rsp_router
    import csw_pkg::*;
(
    input  logic [1:0] hv,
    input  msg_t       h0,
    input  msg_t       h1,
    input  logic       pick,
    input  logic [1:0] irdy,
    output logic [1:0] iv,
    output msg_t       i0,
    output msg_t       i1,
    output logic [1:0] pop
);
    function automatic logic [1:0] targets(input logic [SYM_W-1:0] s);
        unique case (s)
            SYM_P0:  return 2'b01;
            SYM_P1:  return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    logic [1:0] m0, m1;
    logic       ovl, g0, g1, go0, go1;
    msg_t       r0, r1;

    always_comb begin
        m0      = hv[0] ? targets(h0.path[SYM_W-1:0]) : 2'b00;
        m1      = hv[1] ? targets(h1.path[SYM_W-1:0]) : 2'b00;
        ovl     = |(m0 & m1);
        g0      = hv[0] && !(ovl && pick);
        g1      = hv[1] && !(ovl && !pick);
        go0     = g0 && ((m0 & irdy) == m0);
        go1     = g1 && ((m1 & irdy) == m1);
        r0      = h0;
        r1      = h1;
        r0.path = {SYM_P0, h0.path[PATH_W-1:SYM_W]};
        r1.path = {SYM_P1, h1.path[PATH_W-1:SYM_W]};
        iv[0]   = (go0 && m0[0]) || (go1 && m1[0]);
        iv[1]   = (go0 && m0[1]) || (go1 && m1[1]);
        i0      = (go0 && m0[0]) ? r0 : r1;
        i1      = (go0 && m0[1]) ? r0 : r1;
        pop     = {go1, go0};
    end
endmodule

// File: rtl/combining_switch.sv
module combining_switch
    import csw_pkg::*;
#(
    parameter int          LEVEL = 1,
    parameter int          DEPTH = 3,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in0_req_valid,
    output logic             in0_req_ready,
    input  logic [MSG_W-1:0] in0_req_msg,
    input  logic             in1_req_valid,
    output logic             in1_req_ready,
    input  logic [MSG_W-1:0] in1_req_msg,
    output logic             out0_req_valid,
    input  logic             out0_req_ready,
    output logic [MSG_W-1:0] out0_req_msg,
    output logic             out1_req_valid,
    input  logic             out1_req_ready,
    output logic [MSG_W-1:0] out1_req_msg,
    input  logic             out0_rsp_valid,
    output logic             out0_rsp_ready,
    input  logic [MSG_W-1:0] out0_rsp_msg,
    input  logic             out1_rsp_valid,
    output logic             out1_rsp_ready,
    input  logic [MSG_W-1:0] out1_rsp_msg,
    output logic             in0_rsp_valid,
    input  logic             in0_rsp_ready,
    output logic [MSG_W-1:0] in0_rsp_msg,
    output logic             in1_rsp_valid,
    input  logic             in1_rsp_ready,
    output logic [MSG_W-1:0] in1_rsp_msg
);
    logic [15:0]      lfsr;
    logic [1:0]       req_in_v, req_in_r, req_hv, req_pop, req_ov;
    logic [1:0]       rsp_in_v, rsp_in_r, rsp_hv, rsp_pop, rsp_ov;
    logic [MSG_W-1:0] req_in_m [2];
    logic [MSG_W-1:0] rsp_in_m [2];
    msg_t             req_head [2];
    msg_t             rsp_head [2];
    msg_t             req_o0, req_o1, rsp_o0, rsp_o1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr <= SEED;
        else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    assign req_in_v    = {in1_req_valid, in0_req_valid};
    assign req_in_m[0] = in0_req_msg;
    assign req_in_m[1] = in1_req_msg;
    assign rsp_in_v    = {out1_rsp_valid, out0_rsp_valid};
    assign rsp_in_m[0] = out0_rsp_msg;
    assign rsp_in_m[1] = out1_rsp_msg;

    for (genvar g = 0; g < 2; g++) begin : g_port
        csw_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_req_q (
            .clk(clk), .rst_n(rst_n),
            .push_valid(req_in_v[g]), .push_ready(req_in_r[g]), .push_data(req_in_m[g]),
            .pop_valid(req_hv[g]), .pop_ready(req_pop[g]), .pop_data(req_head[g]));
        csw_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_rsp_q (
            .clk(clk), .rst_n(rst_n),
            .push_valid(rsp_in_v[g]), .push_ready(rsp_in_r[g]), .push_data(rsp_in_m[g]),
            .pop_valid(rsp_hv[g]), .pop_ready(rsp_pop[g]), .pop_data(rsp_head[g]));
    end

    csw_req_router #(.LEVEL(LEVEL)) u_req_router (
        .hv(req_hv), .h0(req_head[0]), .h1(req_head[1]), .pick(lfsr[0]),
        .ordy({out1_req_ready, out0_req_ready}),
        .ov(req_ov), .o0(req_o0), .o1(req_o1), .pop(req_pop));

    csw_rsp_router u_rsp_router (
        .hv(rsp_hv), .h0(rsp_head[0]), .h1(rsp_head[1]), .pick(lfsr[1]),
        .irdy({in1_rsp_ready, in0_rsp_ready}),
        .iv(rsp_ov), .i0(rsp_o0), .i1(rsp_o1), .pop(rsp_pop));

    assign in0_req_ready  = req_in_r[0];
    assign in1_req_ready  = req_in_r[1];
    assign out0_rsp_ready = rsp_in_r[0];
    assign out1_rsp_ready = rsp_in_r[1];
    assign out0_req_valid = req_ov[0];
    assign out1_req_valid = req_ov[1];
    assign out0_req_msg   = req_o0;
    assign out1_req_msg   = req_o1;
    assign in0_rsp_valid  = rsp_ov[0];
    assign in1_rsp_valid  = rsp_ov[1];
    assign in0_rsp_msg    = rsp_o0;
    assign in1_rsp_msg    = rsp_o1;

    // R5: a combined request leaving consumes both heads at once
    p_comb_takes_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_req_valid && out0_req_ready && req_o0.path[SYM_W-1:0] == SYM_BOTH)
        |-> req_pop == 2'b11);

    // R2: the appended return symbol is always a legal code
    p_ret_sym_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out1_req_valid |-> out1_req_msg[DATA_W+WORD_W +: SYM_W] != 2'b11);

    // R7: a duplicate reply leaves only when both sides take it
    p_dup_both_sides_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pop[0] && rsp_head[0].path[1])
        |-> in0_rsp_valid && in1_rsp_valid && in0_rsp_ready && in1_rsp_ready);
endmodule

// File: tb/combining_switch_bench.sv
`timescale 1ns/1ps
module combining_switch_bench;
    import csw_pkg::*;

    localparam int LEVEL = 1;
    localparam int KEY_W = (STAGES - LEVEL) * SYM_W;
    localparam int NCYC  = 5000;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n;

    logic in0_req_valid, in1_req_valid, out0_req_ready, out1_req_ready;
    logic out0_rsp_valid, out1_rsp_valid, in0_rsp_ready, in1_rsp_ready;
    logic in0_req_ready, in1_req_ready, out0_rsp_ready, out1_rsp_ready;
    logic out0_req_valid, out1_req_valid, in0_rsp_valid, in1_rsp_valid;
    logic [MSG_W-1:0] in0_req_msg, in1_req_msg, out0_rsp_msg, out1_rsp_msg;
    logic [MSG_W-1:0] out0_req_msg, out1_req_msg, in0_rsp_msg, in1_rsp_msg;

    combining_switch #(.LEVEL(LEVEL), .DEPTH(3)) u_combining_switch (
        .clk(clk), .rst_n(rst_n),
        .in0_req_valid(in0_req_valid), .in0_req_ready(in0_req_ready), .in0_req_msg(in0_req_msg),
        .in1_req_valid(in1_req_valid), .in1_req_ready(in1_req_ready), .in1_req_msg(in1_req_msg),
        .out0_req_valid(out0_req_valid), .out0_req_ready(out0_req_ready), .out0_req_msg(out0_req_msg),
        .out1_req_valid(out1_req_valid), .out1_req_ready(out1_req_ready), .out1_req_msg(out1_req_msg),
        .out0_rsp_valid(out0_rsp_valid), .out0_rsp_ready(out0_rsp_ready), .out0_rsp_msg(out0_rsp_msg),
        .out1_rsp_valid(out1_rsp_valid), .out1_rsp_ready(out1_rsp_ready), .out1_rsp_msg(out1_rsp_msg),
        .in0_rsp_valid(in0_rsp_valid), .in0_rsp_ready(in0_rsp_ready), .in0_rsp_msg(in0_rsp_msg),
        .in1_rsp_valid(in1_rsp_valid), .in1_rsp_ready(in1_rsp_ready), .in1_rsp_msg(in1_rsp_msg));

    int checks = 0;
    int failures = 0;
    int cnt_comb = 0, cnt_conf = 0, cnt_split = 0, cnt_dup = 0, cnt_dup_blk = 0;
    int cnt_rovl = 0, cnt_full = 0, cnt_both = 0;

    msg_t q_req0[$];
    msg_t q_req1[$];
    msg_t q_rsp0[$];
    msg_t q_rsp1[$];

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic msg_t req_fwd(input msg_t m, input logic [1:0] s);
        msg_t r = m;
        r.path = {m.path[PATH_W-3:0], s};
        return r;
    endfunction

    function automatic msg_t rsp_fwd(input msg_t m, input logic [1:0] s);
        msg_t r = m;
        r.path = {s, m.path[PATH_W-1:2]};
        return r;
    endfunction

    function automatic logic [1:0] tmask(input msg_t m);
        if (m.path[1:0] == 2'b00) return 2'b01;
        if (m.path[1:0] == 2'b01) return 2'b10;
        return 2'b11;
    endfunction

    // spec-level model of one request cycle for a given arbitration choice
    task automatic req_expect(input bit pick, output bit [1:0] v, output msg_t d0,
                              output msg_t d1, output bit [1:0] pop, output int kind);
        bit a0, a1, o;
        msg_t h0, h1, m;
        bit [1:0] ordy;
        ordy = {out1_req_ready, out0_req_ready};
        a0 = q_req0.size() > 0;
        a1 = q_req1.size() > 0;
        h0 = a0 ? q_req0[0] : '0;
        h1 = a1 ? q_req1[0] : '0;
        v = 2'b00; pop = 2'b00; d0 = '0; d1 = '0; kind = 0;
        if (a0 && a1 && h0.path[PATH_W-2] == h1.path[PATH_W-2]) begin
            o = h0.path[PATH_W-2];
            if (h0.fn == FN_READ && h1.fn == FN_READ && h0.word == h1.word &&
                h0.path[PATH_W-1 -: KEY_W] == h1.path[PATH_W-1 -: KEY_W]) begin
                kind = 3;
                m = req_fwd(h0, 2'b10);
                if (ordy[o]) pop = 2'b11;
            end else begin
                kind = 4;
                m = pick ? req_fwd(h1, 2'b01) : req_fwd(h0, 2'b00);
                if (ordy[o]) pop = pick ? 2'b10 : 2'b01;
            end
            v[o] = 1'b1;
            if (o) d1 = m; else d0 = m;
        end else begin
            kind = (a0 && a1) ? 2 : ((a0 || a1) ? 1 : 0);
            if (a0) begin
                o = h0.path[PATH_W-2];
                v[o] = 1'b1;
                if (o) d1 = req_fwd(h0, 2'b00); else d0 = req_fwd(h0, 2'b00);
                pop[0] = ordy[o];
            end
            if (a1) begin
                o = h1.path[PATH_W-2];
                v[o] = 1'b1;
                if (o) d1 = req_fwd(h1, 2'b01); else d0 = req_fwd(h1, 2'b01);
                pop[1] = ordy[o];
            end
        end
    endtask

    // spec-level model of one reply cycle for a given arbitration choice
    task automatic rsp_expect(input bit pick, output bit [1:0] v, output msg_t d0,
                              output msg_t d1, output bit [1:0] pop, output int kind);
        bit a0, a1;
        msg_t h0, h1;
        bit [1:0] m0, m1, irdy;
        irdy = {in1_rsp_ready, in0_rsp_ready};
        a0 = q_rsp0.size() > 0;
        a1 = q_rsp1.size() > 0;
        h0 = a0 ? q_rsp0[0] : '0;
        h1 = a1 ? q_rsp1[0] : '0;
        m0 = a0 ? tmask(h0) : 2'b00;
        m1 = a1 ? tmask(h1) : 2'b00;
        v = 2'b00; pop = 2'b00; d0 = '0; d1 = '0;
        kind = ((m0 == 2'b11) || (m1 == 2'b11)) ? 7 : 3;
        if ((m0 & m1) != 2'b00) begin
            kind = 9;
            if (pick) m0 = 2'b00; else m1 = 2'b00;
        end
        if (m0 != 2'b00 && (m0 & irdy) == m0) begin
            pop[0] = 1'b1;
            if (m0[0]) begin v[0] = 1'b1; d0 = rsp_fwd(h0, 2'b00); end
            if (m0[1]) begin v[1] = 1'b1; d1 = rsp_fwd(h0, 2'b00); end
        end
        if (m1 != 2'b00 && (m1 & irdy) == m1) begin
            pop[1] = 1'b1;
            if (m1[0]) begin v[0] = 1'b1; d0 = rsp_fwd(h1, 2'b01); end
            if (m1[1]) begin v[1] = 1'b1; d1 = rsp_fwd(h1, 2'b01); end
        end
    endtask

    function automatic bit same_out(input bit [1:0] ev, input msg_t e0, input msg_t e1,
                                    input bit [1:0] av, input msg_t x0, input msg_t x1);
        return (ev == av) && (!ev[0] || e0 == x0) && (!ev[1] || e1 == x1);
    endfunction

    function automatic msg_t rnd_req();
        msg_t m;
        m.fn = ($urandom_range(0, 3) == 0) ? FN_WRITE : FN_READ;
        for (int s = 0; s < STAGES; s++)
            m.path[s*2 +: 2] = (s >= LEVEL) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(0, 2));
        m.word = WORD_W'($urandom_range(0, 1));
        m.data = DATA_W'($urandom);
        return m;
    endfunction

    function automatic msg_t rnd_rsp();
        msg_t m;
        m.fn = FN_READ;
        for (int s = 0; s < STAGES; s++) m.path[s*2 +: 2] = 2'($urandom_range(0, 2));
        m.word = WORD_W'($urandom);
        m.data = DATA_W'($urandom);
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {in0_req_valid, in1_req_valid, out0_rsp_valid, out1_rsp_valid} = '0;
        {out0_req_ready, out1_req_ready, in0_rsp_ready, in1_rsp_ready} = '0;
        in0_req_msg = '0; in1_req_msg = '0; out0_rsp_msg = '0; out1_rsp_msg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk({out0_req_valid, out1_req_valid, in0_rsp_valid, in1_rsp_valid} == 4'b0000 &&
            {in0_req_ready, in1_req_ready, out0_rsp_ready, out1_rsp_ready} == 4'b1111,
            "R1 reset state",
            $sformatf("v=%b r=%b", {out0_req_valid, out1_req_valid, in0_rsp_valid, in1_rsp_valid},
                      {in0_req_ready, in1_req_ready, out0_rsp_ready, out1_rsp_ready}),
            "v=0000 r=1111");

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit stall;
            bit [3:0] er;
            bit [1:0] va, vb, pa, pb, av, pk;
            msg_t a0, a1, b0, b1;
            int ka, kb;
            bit oka, okb, req_moved, rsp_moved;
            @(negedge clk);
            stall = (cyc % 250) < 30;
            in0_req_valid  = $urandom_range(0, 9) < 6;
            in1_req_valid  = $urandom_range(0, 9) < 6;
            in0_req_msg    = rnd_req();
            in1_req_msg    = rnd_req();
            out0_rsp_valid = $urandom_range(0, 9) < 5;
            out1_rsp_valid = $urandom_range(0, 9) < 5;
            out0_rsp_msg   = rnd_rsp();
            out1_rsp_msg   = rnd_rsp();
            out0_req_ready = !stall && $urandom_range(0, 3) != 0;
            out1_req_ready = !stall && $urandom_range(0, 3) != 0;
            in0_rsp_ready  = !stall && $urandom_range(0, 3) != 0;
            in1_rsp_ready  = !stall && $urandom_range(0, 3) != 0;
            #1;
            er = {q_req0.size() < 3, q_req1.size() < 3, q_rsp0.size() < 3, q_rsp1.size() < 3};
            chk({in0_req_ready, in1_req_ready, out0_rsp_ready, out1_rsp_ready} == er,
                "R8 channel ready",
                $sformatf("%b", {in0_req_ready, in1_req_ready, out0_rsp_ready, out1_rsp_ready}),
                $sformatf("%b", er));
            if (er != 4'b1111) cnt_full++;

            // requests
            req_expect(1'b0, va, a0, a1, pa, ka);
            req_expect(1'b1, vb, b0, b1, pb, kb);
            av  = {out1_req_valid, out0_req_valid};
            oka = same_out(va, a0, a1, av, msg_t'(out0_req_msg), msg_t'(out1_req_msg));
            okb = same_out(vb, b0, b1, av, msg_t'(out0_req_msg), msg_t'(out1_req_msg));
            pk  = oka ? pa : pb;
            chk(oka || okb,
                (ka == 3) ? "R5 combined read" : (ka == 4) ? "R6 request conflict" :
                (ka == 2) ? "R4 split outputs" : "R2 request route",
                $sformatf("v=%b o0=%h o1=%h", av, out0_req_msg, out1_req_msg),
                $sformatf("v=%b o0=%h o1=%h", va, a0, a1));
            if (ka == 3 && pk == 2'b11) cnt_comb++;
            if (ka == 4 && pk != 2'b00) cnt_conf++;
            if (ka == 2 && pk == 2'b11) cnt_split++;
            req_moved = pk != 2'b00;
            if (pk[0]) void'(q_req0.pop_front());
            if (pk[1]) void'(q_req1.pop_front());
            if (in0_req_valid && er[3]) q_req0.push_back(msg_t'(in0_req_msg));
            if (in1_req_valid && er[2]) q_req1.push_back(msg_t'(in1_req_msg));

            // replies
            rsp_expect(1'b0, va, a0, a1, pa, ka);
            rsp_expect(1'b1, vb, b0, b1, pb, kb);
            av  = {in1_rsp_valid, in0_rsp_valid};
            oka = same_out(va, a0, a1, av, msg_t'(in0_rsp_msg), msg_t'(in1_rsp_msg));
            okb = same_out(vb, b0, b1, av, msg_t'(in0_rsp_msg), msg_t'(in1_rsp_msg));
            pk  = oka ? pa : pb;
            chk(oka || okb,
                (ka == 9) ? "R9 reply overlap" : (ka == 7) ? "R7 duplicate reply" : "R3 reply route",
                $sformatf("v=%b i0=%h i1=%h", av, in0_rsp_msg, in1_rsp_msg),
                $sformatf("v=%b i0=%h i1=%h", va, a0, a1));
            if (av == 2'b11 && in0_rsp_msg == in1_rsp_msg) cnt_dup++;
            if (ka == 7 && (in0_rsp_ready ^ in1_rsp_ready)) cnt_dup_blk++;
            if (ka == 9 && pk != 2'b00) cnt_rovl++;
            rsp_moved = pk != 2'b00;
            if (pk[0]) void'(q_rsp0.pop_front());
            if (pk[1]) void'(q_rsp1.pop_front());
            if (out0_rsp_valid && er[1]) q_rsp0.push_back(msg_t'(out0_rsp_msg));
            if (out1_rsp_valid && er[0]) q_rsp1.push_back(msg_t'(out1_rsp_msg));
            if (req_moved && rsp_moved) cnt_both++;
        end

        chk(cnt_comb > 0, "R5 combining reached", $sformatf("%0d", cnt_comb), ">0");
        chk(cnt_conf > 0, "R6 conflict reached", $sformatf("%0d", cnt_conf), ">0");
        chk(cnt_split > 0, "R4 parallel forward reached", $sformatf("%0d", cnt_split), ">0");
        chk(cnt_dup > 0, "R7 duplicate delivered", $sformatf("%0d", cnt_dup), ">0");
        chk(cnt_dup_blk > 0, "R7 duplicate half-blocked reached", $sformatf("%0d", cnt_dup_blk), ">0");
        chk(cnt_rovl > 0, "R9 reply overlap reached", $sformatf("%0d", cnt_rovl), ">0");
        chk(cnt_full > 0, "R8 full channel reached", $sformatf("%0d", cnt_full), ">0");
        chk(cnt_both > 0, "R10 both directions moved", $sformatf("%0d", cnt_both), ">0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule